// File: doc/BRIEF.md
# Gated Eighteen-Way Clock Fanout

This block takes one input clock and copies it, without inversion, onto eighteen outputs. Each output is modelled as a pad: a data value plus a drive-enable. A single global enable pin decides whether any pad drives at all. When that pin is low, every pad floats. When it is high, every pad drives, and each output either follows the input clock or is held low, according to its own bit in a 24-bit configuration word.

The configuration word is written from another clock domain. Each enable bit is resynchronised into the input clock domain through a parameterised flop chain. It is then captured on the falling edge of the input clock. A gating change can therefore only take effect while the clock is low, so an output never sees a shortened high pulse or a runt. The global pin bypasses all of this and acts on the drive-enables combinationally.

Top module: `clkfan18_gate`

## Requirements
- R1: Each enabled output is a non-inverted copy of `clk_in`: high while `clk_in` is high and low while it is low.
- R2: When `out_en_all` is 0, every bit of `clk_drv` is 0 (pad floating) whatever the other inputs are. When it is 1, every bit of `clk_drv` is 1. The pin acts combinationally, with no clock edge needed.
- R3: An output whose enable bit is 0 holds `clk_val` at 0 in both clock phases.
- R4: An output whose enable bit is 1 toggles with the input clock in every cycle.
- R5: Configuration bits 0 to 15 enable outputs 0 to 15 respectively (bit n enables output n). A bit value of 1 means enabled and 0 means disabled.
- R6: Configuration bit 22 enables output 16 and bit 23 enables output 17.
- R7: Configuration bits 16 to 21 are reserved and have no effect on any output.
- R8: Call the first rising edge of `clk_in` after a configuration change edge 1. With the default two synchroniser stages, the outputs keep their old gating in the high phases after edges 1 and 2, and show the new gating from the high phase after edge 3.
- R9: No output is ever high while `clk_in` is low; gating changes occur only in the low phase.
- R10: While `rst_n` is low, all gates are disabled, so every `clk_val` bit is 0 and `clk_drv` still follows R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Clock to be distributed |
| rst_n | input | 1 | Asynchronous active-low reset of synchronisers and gates |
| out_en_all | input | 1 | Global pad enable; 0 floats all outputs |
| cfg_word | input | 24 | Enable bits, mapped to outputs as in R5 to R7 |
| clk_val | output | 18 | Value driven onto each output pad |
| clk_drv | output | 18 | Drive-enable of each output pad (1 = driving) |

## Verification
A wrong synchroniser or gate state shows at the ports within one clock period. A stuck gate gives an output that is low in a high phase, or that toggles when it should be quiet. A gate that updates on the wrong edge shows either an output that is high during a low phase, or a gating change one cycle earlier or later than R8 allows. A mistake in the bit mapping shows up as the wrong output responding when a single configuration bit is set, so the bench walks a lone 1 across all 24 bits.

// File: rtl/clkfan_pkg.sv
package clkfan_pkg;
   localparam int unsigned CF_BYTE_W     = 8;
   localparam int unsigned CF_LINEAR_OUT = 16;
   localparam int unsigned CF_HI_BASE    = 22;
   localparam int unsigned CF_MAX_OUT    = 18;

   // Configuration-word bit position that enables a given output.
   function automatic int unsigned cfg_bit_of(input int unsigned out_idx);
      if (out_idx < CF_LINEAR_OUT)
         return out_idx;
      return CF_HI_BASE + (out_idx - CF_LINEAR_OUT);
   endfunction
endpackage

// File: rtl/clkfan_cfg_map.sv
module clkfan_cfg_map #(
   parameter int unsigned NUM_OUT = 18,
   parameter int unsigned CFG_W   = 24
) (
   input  logic [CFG_W-1:0]   cfg_word,
   output logic [NUM_OUT-1:0] en_raw
);
   import clkfan_pkg::*;

   for (genvar i = 0; i < NUM_OUT; i++) begin : g_sel
      localparam int unsigned SRC = cfg_bit_of(i);
      if (SRC >= CFG_W) begin : g_bad
         $error("clkfan_cfg_map: output %0d maps outside cfg word", i);
      end
      assign en_raw[i] = cfg_word[SRC];
   end
endmodule

// File: rtl/clkfan_en_sync.sv
module clkfan_en_sync #(
   parameter int unsigned W      = 18,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk_in,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES == 0) begin : g_bypass
      assign q = d;
   end else begin : g_chain
      logic [STAGES-1:0][W-1:0] st;
      always_ff @(posedge clk_in or negedge rst_n) begin
         if (!rst_n) begin
            st <= '0;
         end else begin
            st[0] <= d;
            for (int k = 1; k < STAGES; k++)
               st[k] <= st[k-1];
         end
      end
      assign q = st[STAGES-1];
   end
endmodule

// File: rtl/clkfan_gate_cell.sv
module clkfan_gate_cell (
   input  logic clk_in,
   input  logic rst_n,
   input  logic en,
   output logic gclk
);
   logic en_q;

   // Captured on the falling edge: the AND input only moves while clk_in is low.
   always_ff @(negedge clk_in or negedge rst_n) begin
      if (!rst_n)
         en_q <= 1'b0;
      else
         en_q <= en;
   end

   assign gclk = clk_in & en_q;
endmodule

// File: rtl/clkfan18_gate.sv
module clkfan18_gate #(
   parameter int unsigned NUM_OUT     = 18,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned CFG_BYTES   = 3
) (
   input  logic                                  clk_in,
   input  logic                                  rst_n,
   input  logic                                  out_en_all,
   input  logic [CFG_BYTES*clkfan_pkg::CF_BYTE_W-1:0] cfg_word,
   output logic [NUM_OUT-1:0]                    clk_val,
   output logic [NUM_OUT-1:0]                    clk_drv
);
   import clkfan_pkg::*;

   localparam int unsigned CFG_W = CFG_BYTES * CF_BYTE_W;

   if (NUM_OUT < CF_LINEAR_OUT || NUM_OUT > CF_MAX_OUT) begin : g_bad_num
      $error("clkfan18_gate: NUM_OUT must be between 16 and 18");
   end
   if (CFG_BYTES != 3) begin : g_bad_bytes
      $error("clkfan18_gate: CFG_BYTES must be 3");
   end
   if (SYNC_STAGES > 4) begin : g_bad_sync
      $error("clkfan18_gate: SYNC_STAGES above 4 is not supported");
   end

   logic [NUM_OUT-1:0] en_raw;
   logic [NUM_OUT-1:0] en_sync;

   clkfan_cfg_map #(.NUM_OUT(NUM_OUT), .CFG_W(CFG_W)) u_map (
      .cfg_word (cfg_word),
      .en_raw   (en_raw)
   );

   clkfan_en_sync #(.W(NUM_OUT), .STAGES(SYNC_STAGES)) u_sync (
      .clk_in (clk_in),
      .rst_n  (rst_n),
      .d      (en_raw),
      .q      (en_sync)
   );

   for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
      clkfan_gate_cell u_gate (
         .clk_in (clk_in),
         .rst_n  (rst_n),
         .en     (en_sync[i]),
         .gclk   (clk_val[i])
      );
      assign clk_drv[i] = out_en_all;
   end
endmodule

// File: rtl/clkfan_chk.sv
module clkfan_chk #(
   parameter int unsigned NUM_OUT     = 18,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned CFG_W       = 24
) (
   input logic               clk_in,
   input logic               rst_n,
   input logic [CFG_W-1:0]   cfg_word,
   input logic [NUM_OUT-1:0] clk_val,
   input logic [NUM_OUT-1:0] clk_drv
);
   localparam int unsigned LAT = SYNC_STAGES + 1;

   logic [NUM_OUT-1:0] exp_now;
   logic [NUM_OUT-1:0] exp_q;
   logic [3:0]         stable_cnt;

   always_comb begin
      for (int i = 0; i < NUM_OUT; i++)
         exp_now[i] = (i < 16) ? cfg_word[i] : cfg_word[i + 6];
   end

   always_ff @(negedge clk_in or negedge rst_n) begin
      if (!rst_n) begin
         exp_q      <= '0;
         stable_cnt <= '0;
      end else begin
         exp_q <= exp_now;
         if (exp_now != exp_q)
            stable_cnt <= '0;
         else if (stable_cnt != 4'hF)
            stable_cnt <= stable_cnt + 4'd1;
      end
   end

   // R9: sampled just before a rising edge, clk_in was low, so all outputs must be low
   p_low_phase_r9: assert property (@(posedge clk_in) disable iff (!rst_n)
      clk_val == '0);

   // R4 with R5/R6: once the mapped enables have settled, every enabled output is high in the high phase
   p_follow_r4: assert property (@(negedge clk_in) disable iff (!rst_n)
      (int'(stable_cnt) >= LAT && exp_now == exp_q) |-> ((clk_val & exp_now) == exp_now));

   // R3 with R7: settled disabled outputs stay low
   p_disabled_low_r3: assert property (@(negedge clk_in) disable iff (!rst_n)
      (int'(stable_cnt) >= LAT && exp_now == exp_q) |-> ((clk_val & ~exp_now) == '0));

   // R2: pads drive all together or float all together
   p_drv_uniform_r2: assert property (@(negedge clk_in) disable iff (!rst_n)
      (clk_drv == '0) || (&clk_drv));
endmodule

bind clkfan18_gate clkfan_chk #(
   .NUM_OUT     (NUM_OUT),
   .SYNC_STAGES (SYNC_STAGES),
   .CFG_W       (CFG_BYTES * 8)
) u_chk (
   .clk_in   (clk_in),
   .rst_n    (rst_n),
   .cfg_word (cfg_word),
   .clk_val  (clk_val),
   .clk_drv  (clk_drv)
);

// File: tb/clkfan18_gate_tb.sv
`timescale 1ns/100ps
module clkfan18_gate_tb;
   logic        clk;
   logic        rst_n;
   logic        oe;
   logic [23:0] cfg;
   logic [17:0] val;
   logic [17:0] drv;

   int checks = 0;
   int errors = 0;
   int cyc    = 0;

   clkfan18_gate u_dut (
      .clk_in     (clk),
      .rst_n      (rst_n),
      .out_en_all (oe),
      .cfg_word   (cfg),
      .clk_val    (val),
      .clk_drv    (drv)
   );

   initial begin
      clk = 1'b0;
      forever #2.5 clk = ~clk;
   end

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 100000) begin
         errors = errors + 1;
         $display("FAIL watchdog: run hung, actual %0d cycles expected < 100000", cyc);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   function automatic logic [17:0] map_of(input logic [23:0] c);
      logic [17:0] m;
      for (int i = 0; i < 18; i++)
         m[i] = (i < 16) ? c[i] : c[i + 6];
      return m;
   endfunction

   task automatic chk(input string tag, input logic [17:0] act, input logic [17:0] exp);
      checks = checks + 1;
      if (act !== exp) begin
         errors = errors + 1;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // Apply a configuration after a rising edge, let it settle, then check both phases.
   task automatic apply_and_check(input logic [23:0] c, input logic o, input string tag);
      @(posedge clk); #1;
      cfg = c;
      oe  = o;
      repeat (4) @(posedge clk);
      #1;
      chk({tag, " high phase (R1 R4 R5 R6 R7)"}, val, map_of(c));
      chk({tag, " drive (R2)"}, drv, {18{o}});
      @(negedge clk); #1;
      chk({tag, " low phase (R3 R9)"}, val, 18'h0);
   endtask

   initial begin
      rst_n = 1'b0;
      oe    = 1'b1;
      cfg   = 24'hFFFFFF;
      repeat (3) @(posedge clk);
      #1;
      chk("reset outputs low R10", val, 18'h0);
      chk("reset drive follows pin R10", drv, 18'h3FFFF);
      oe = 1'b0;
      #0.5;
      chk("reset pin low floats R2", drv, 18'h0);
      oe = 1'b1;
      @(negedge clk); #1;
      rst_n = 1'b1;
      cfg   = 24'h0;

      apply_and_check(24'h000000, 1'b1, "all off R3");
      apply_and_check(24'hFFFFFF, 1'b1, "all on R4");
      apply_and_check(24'hC0FFFF, 1'b0, "pin low R2");

      // R5 R6 R7: lone bit walked across the whole word
      for (int b = 0; b < 24; b++)
         apply_and_check(24'h1 << b, 1'b1, $sformatf("walk bit %0d R5 R6 R7", b));

      apply_and_check(24'h3F0000, 1'b1, "reserved only R7");
      apply_and_check(24'hAA5555, 1'b1, "pattern a R5 R6");
      apply_and_check(24'h55AAAA, 1'b1, "pattern b R5 R6");
      apply_and_check(24'h7F00FF, 1'b1, "pattern c R6 R7");

      // R8: latency of a gating change
      apply_and_check(24'h000F0F, 1'b1, "latency base R8");
      @(posedge clk); #1;
      cfg = 24'hC0F0F0;
      @(posedge clk); #1;
      chk("R8 old after edge 1", val, 18'h00F0F);
      @(posedge clk); #1;
      chk("R8 old after edge 2", val, 18'h00F0F);
      @(posedge clk); #1;
      chk("R8 new after edge 3", val, 18'h3F0F0);

      // R2: global pin is combinational, no edge between change and sample
      @(posedge clk); #1;
      oe = 1'b0;
      #0.5;
      chk("R2 float without edge", drv, 18'h0);
      chk("R2 value unaffected R4", val, 18'h3F0F0);
      oe = 1'b1;
      #0.5;
      chk("R2 drive without edge", drv, 18'h3FFFF);

      // R10: reset mid-run forces outputs low
      @(posedge clk); #1;
      rst_n = 1'b0;
      #0.5;
      chk("R10 async reset clears", val, 18'h0);
      @(posedge clk); #1;
      chk("R10 held in reset", val, 18'h0);
      rst_n = 1'b1;

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule